// File: doc/BRIEF.md
# Oscillator Clock Monitor with Self-Clock Fallback

This block runs on an always-present internal self clock and watches an external oscillator signal for activity. The oscillator is treated as data: it is synchronised into the self-clock domain, and every transition counts as an edge. If no edge arrives for a set number of self-clock cycles, the oscillator is declared lost. What happens then depends on two configuration bits. The monitor-enable bit arms the detector. The self-fallback-enable bit chooses between switching the system onto the self clock and asking for a chip reset.

While the block runs on the self clock, a quality check counts consecutive oscillator edges. An edge only counts when it arrives soon enough after the previous one. Once enough edges have counted, the block moves back to the oscillator. A reset event puts both configuration bits back to one and sends the block into self-clock mode straight away. It also starts a fixed-length reset sequence. The quality check runs alongside that sequence, so the block can return to the oscillator before the sequence ends. The clock select is modelled as a registered indicator rather than a real glitch-free multiplexer.

Top module: `clk_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `self_mode` is 1, `sel_osc` is 0, `mon_rst_req` is 0, and both configuration bits hold 1.
- R2: After `rst` falls, `rst_seq_active` stays 1 for exactly RST_SEQ clock cycles and then drops to 0.
- R3: In self-clock mode, the block switches to the oscillator (`sel_osc`=1, `self_mode`=0) after QUAL_EDGES consecutive counted edges. An edge counts only when it arrives fewer than QUAL_WIN cycles after the previous one. With an oscillator half-period of H cycles (H ≤ QUAL_WIN), the switch lands between 3H+1 and 4H+6 cycles after the oscillator starts.
- R4: A gap of QUAL_WIN cycles with no edge restarts the quality count. An oscillator whose half-period exceeds QUAL_WIN therefore never ends self-clock mode.
- R5: The return to the oscillator after a reset can happen while `rst_seq_active` is still 1.
- R6: An edge is any change of the synchronised `osc_in`, whether rising or falling. Loss is declared once LOSS_LIMIT self-clock cycles pass without an edge, and never while the oscillator toggles with a half-period of at most LOSS_LIMIT.
- R7: When monitor-enable is 1 and self-fallback-enable is 1, a loss moves the block to self-clock mode and raises no reset request.
- R8: When monitor-enable is 1 and self-fallback-enable is 0, a loss raises `mon_rst_req`. The block keeps the oscillator selected, and the request clears once edges return.
- R9: When monitor-enable is 0, a loss changes neither the mode nor `mon_rst_req`.
- R10: A write that clears self-fallback-enable while the block is in self-clock mode is ignored. A later or ongoing loss still raises no request.
- R11: A reset event overrides any configuration. Starting from the oscillator with both bits at 0, the first cycle after the event shows `self_mode`=1 and `sel_osc`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running self clock |
| rst | input | 1 | Reset event, synchronous, active high |
| osc_in | input | 1 | Oscillator clock, sampled as data |
| cfg_we | input | 1 | Write strobe for the configuration bits |
| cfg_mon_en | input | 1 | Monitor-enable value to write |
| cfg_self_en | input | 1 | Self-fallback-enable value to write |
| sel_osc | output | 1 | 1 when the oscillator is the selected clock |
| self_mode | output | 1 | 1 while running in self-clock mode |
| mon_rst_req | output | 1 | Reset request raised by the clock monitor |
| rst_seq_active | output | 1 | 1 while the post-reset sequence is counting |

## Verification
The main sweep starts a periodic oscillator with every half-period from 1 to 8 cycles after a reset. Half-periods within the quality window must end self-clock mode inside an arithmetic bound and while the reset sequence is still running. Longer ones must never end it, which separates the window test from the loss test (every swept period is below the loss limit). The oscillator is then stopped under each configuration-bit combination: monitor disabled, fallback enabled, request enabled, and a fallback-clear written while already in self mode. Each combination has its own expected mode and request outcome. Finally, a period that is too slow and then an acceptable one are applied after a loss, which shows that recovery still works and that a slow clock keeps restarting the count.

// File: rtl/cm_pkg.sv
package cm_pkg;

    typedef enum logic {
        MODE_OSC  = 1'b0,
        MODE_SELF = 1'b1
    } clk_mode_e;

    typedef struct packed {
        logic mon_en;
        logic self_en;
    } mon_cfg_t;

    localparam mon_cfg_t CFG_RESET = '{mon_en: 1'b1, self_en: 1'b1};

endpackage

// File: rtl/cm_osc_edge.sv
module cm_osc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_in,
    output logic osc_edge
);
    // pipe_q[SYNC_STAGES-1:0] synchronise, pipe_q[SYNC_STAGES] holds the prior value
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[SYNC_STAGES-1:0], osc_in};
        end
    end

    assign osc_edge = pipe_q[SYNC_STAGES] ^ pipe_q[SYNC_STAGES-1];

endmodule

// File: rtl/cm_gap_timer.sv
module cm_gap_timer #(
    parameter int LOSS_LIMIT = 16,
    parameter int GW         = $clog2(LOSS_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          osc_edge,
    output logic [GW-1:0] gap_cnt,
    output logic          clk_lost
);
    localparam logic [GW-1:0] LIMIT_V = GW'(LOSS_LIMIT);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (osc_edge) begin
            gap_q <= '0;
        end else if (gap_q != LIMIT_V) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign gap_cnt  = gap_q;
    assign clk_lost = (gap_q >= LIMIT_V);

endmodule

// File: rtl/cm_quality.sv
module cm_quality #(
    parameter int QUAL_EDGES = 16,
    parameter int QUAL_WIN   = 8,
    parameter int GW         = 5,
    parameter int QW         = $clog2(QUAL_EDGES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          check_en,
    input  logic          osc_edge,
    input  logic [GW-1:0] gap_cnt,
    output logic          osc_good,
    output logic [QW-1:0] good_cnt
);
    localparam logic [GW-1:0] WIN_V  = GW'(QUAL_WIN);
    localparam logic [QW-1:0] GOAL_V = QW'(QUAL_EDGES);

    logic [QW-1:0] cnt_q;
    logic          in_window;

    assign in_window = (gap_cnt < WIN_V);

    always_ff @(posedge clk) begin
        if (rst || !check_en) begin
            cnt_q <= '0;
        end else if (osc_edge) begin
            if (!in_window) begin
                cnt_q <= QW'(1);              // late edge starts a fresh run
            end else if (cnt_q != GOAL_V) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (!in_window) begin
            cnt_q <= '0;                      // window expired with no edge
        end
    end

    assign good_cnt = cnt_q;
    assign osc_good = (cnt_q == GOAL_V);

endmodule

// File: rtl/clk_monitor.sv
module clk_monitor
    import cm_pkg::*;
#(
    parameter int LOSS_LIMIT  = 16,
    parameter int QUAL_WIN    = 8,
    parameter int QUAL_EDGES  = 16,
    parameter int RST_SEQ     = 192,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_in,
    input  logic cfg_we,
    input  logic cfg_mon_en,
    input  logic cfg_self_en,
    output logic sel_osc,
    output logic self_mode,
    output logic mon_rst_req,
    output logic rst_seq_active
);
    localparam int GW = $clog2(LOSS_LIMIT + 1);
    localparam int QW = $clog2(QUAL_EDGES + 1);
    localparam int SW = $clog2(RST_SEQ + 1);
    localparam logic [SW-1:0] SEQ_V = SW'(RST_SEQ);

    logic          edge_w;
    logic [GW-1:0] gap_w;
    logic          loss_w;
    logic          osc_ok_w;
    logic [QW-1:0] q_cnt_w;

    mon_cfg_t      cfg_q;
    clk_mode_e     mode_q;
    logic          req_q;
    logic [SW-1:0] seq_q;
    logic          self_en_w;

    cm_osc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .osc_in   (osc_in),
        .osc_edge (edge_w)
    );

    cm_gap_timer #(.LOSS_LIMIT(LOSS_LIMIT), .GW(GW)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .osc_edge (edge_w),
        .gap_cnt  (gap_w),
        .clk_lost (loss_w)
    );

    cm_quality #(
        .QUAL_EDGES (QUAL_EDGES),
        .QUAL_WIN   (QUAL_WIN),
        .GW         (GW),
        .QW         (QW)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .check_en (mode_q == MODE_SELF),
        .osc_edge (edge_w),
        .gap_cnt  (gap_w),
        .osc_good (osc_ok_w),
        .good_cnt (q_cnt_w)
    );

    // configuration: fallback enable cannot be cleared while in self mode
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_we) begin
            cfg_q.mon_en  <= cfg_mon_en;
            cfg_q.self_en <= cfg_self_en | (mode_q == MODE_SELF);
        end
    end

    // clock mode and reset request
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_SELF;
            req_q  <= 1'b0;
        end else begin
            unique case (mode_q)
                MODE_OSC: begin
                    if (loss_w && cfg_q.mon_en && cfg_q.self_en) begin
                        mode_q <= MODE_SELF;
                    end
                end
                MODE_SELF: begin
                    if (osc_ok_w) begin
                        mode_q <= MODE_OSC;
                    end
                end
                default: mode_q <= MODE_SELF;
            endcase
            req_q <= (mode_q == MODE_OSC) && cfg_q.mon_en && !cfg_q.self_en && loss_w;
        end
    end

    // reset sequence length, runs beside the quality check
    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SEQ_V;
        end else if (seq_q != '0) begin
            seq_q <= seq_q - 1'b1;
        end
    end

    assign self_en_w      = cfg_q.self_en;
    assign sel_osc        = (mode_q == MODE_OSC);
    assign self_mode      = (mode_q == MODE_SELF);
    assign mon_rst_req    = req_q;
    assign rst_seq_active = (seq_q != '0);

endmodule

// File: rtl/clk_monitor_chk.sv
module clk_monitor_chk #(
    parameter int QUAL_EDGES = 16
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              self_mode,
    input logic                              mon_rst_req,
    input logic                              rst_seq_active,
    input logic                              loss,
    input logic                              osc_ok,
    input logic                              self_en,
    input logic [$clog2(QUAL_EDGES + 1)-1:0] q_cnt
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (self_mode && !mon_rst_req && rst_seq_active)); // R1

    AST_EXIT_NEEDS_QUALITY: assert property (@(posedge clk) disable iff (rst)
        $fell(self_mode) |-> $past(osc_ok)); // R3

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        q_cnt <= ($clog2(QUAL_EDGES + 1))'(QUAL_EDGES)); // R4

    AST_ENTRY_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
        $rose(self_mode) |-> ($past(loss) && $past(self_en))); // R7

    AST_REQ_NOT_IN_SELF: assert property (@(posedge clk) disable iff (rst)
        mon_rst_req |-> !self_mode); // R8

    AST_FALLBACK_HELD: assert property (@(posedge clk) disable iff (rst)
        self_mode |-> self_en); // R10

endmodule

bind clk_monitor clk_monitor_chk #(.QUAL_EDGES(QUAL_EDGES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .self_mode      (self_mode),
    .mon_rst_req    (mon_rst_req),
    .rst_seq_active (rst_seq_active),
    .loss           (loss_w),
    .osc_ok         (osc_ok_w),
    .self_en        (self_en_w),
    .q_cnt          (q_cnt_w)
);

// File: tb/clk_monitor_bench.sv
module clk_monitor_bench;
    localparam int LL = 8;
    localparam int QWIN = 4;
    localparam int QE = 4;
    localparam int RS = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_in = 1'b0;
    logic cfg_we = 1'b0;
    logic cfg_mon_en = 1'b0;
    logic cfg_self_en = 1'b0;
    logic sel_osc, self_mode, mon_rst_req, rst_seq_active;

    int n_chk = 0;
    int n_fail = 0;
    int half = 2;
    bit osc_run = 1'b0;
    int ph = 0;

    clk_monitor #(
        .LOSS_LIMIT (LL),
        .QUAL_WIN   (QWIN),
        .QUAL_EDGES (QE),
        .RST_SEQ    (RS)
    ) u_clk_monitor (
        .clk            (clk),
        .rst            (rst),
        .osc_in         (osc_in),
        .cfg_we         (cfg_we),
        .cfg_mon_en     (cfg_mon_en),
        .cfg_self_en    (cfg_self_en),
        .sel_osc        (sel_osc),
        .self_mode      (self_mode),
        .mon_rst_req    (mon_rst_req),
        .rst_seq_active (rst_seq_active)
    );

    always #5 clk = ~clk;

    // oscillator model: toggles every 'half' self-clock cycles
    initial begin
        forever begin
            @(negedge clk);
            if (osc_run) begin
                if (ph >= half - 1) begin
                    osc_in = ~osc_in;
                    ph = 0;
                end else begin
                    ph++;
                end
            end else begin
                ph = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic wr(input bit m, input bit s);
        cfg_we = 1'b1;
        cfg_mon_en = m;
        cfg_self_en = s;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int ex;
        bit seqa;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk(self_mode == 1'b1, "R1 self_mode", self_mode, 1);
        chk(sel_osc == 1'b0, "R1 sel_osc", sel_osc, 0);
        chk(mon_rst_req == 1'b0, "R1 mon_rst_req", mon_rst_req, 0);
        // R2 exact sequence length
        cyc(RS - 2);
        chk(rst_seq_active == 1'b1, "R2 last active cycle", rst_seq_active, 1);
        cyc(1);
        chk(rst_seq_active == 1'b0, "R2 sequence over", rst_seq_active, 0);

        // R3 / R4 / R5 sweep over oscillator half-periods
        for (int h = 1; h <= 8; h++) begin
            osc_run = 1'b0;
            do_reset();
            half = h;
            osc_run = 1'b1;
            ex = -1;
            seqa = 1'b0;
            for (int k = 1; k <= 60; k++) begin
                cyc(1);
                if (ex < 0 && !self_mode) begin
                    ex = k;
                    seqa = rst_seq_active;
                end
            end
            if (h <= QWIN) begin
                chk(ex >= 3 * h + 1 && ex <= 4 * h + 6, "R3 exit cycle", ex, 4 * h);
                chk(seqa == 1'b1, "R5 exit during sequence", seqa, 1);
                chk(sel_osc == 1'b1, "R3 sel_osc", sel_osc, 1);
            end else begin
                chk(ex < 0, "R4 slow oscillator stays in self mode", ex, -1);
            end
        end

        // R6 / R8 request path
        osc_run = 1'b0;
        do_reset();
        half = 2;
        osc_run = 1'b1;
        cyc(30);
        chk(self_mode == 1'b0, "R3 back on oscillator", self_mode, 0);
        wr(1'b1, 1'b0);
        cyc(20);
        chk(mon_rst_req == 1'b0, "R6 no loss while toggling", mon_rst_req, 0);
        osc_run = 1'b0;
        cyc(LL + 1);
        chk(mon_rst_req == 1'b0, "R6 not before limit", mon_rst_req, 0);
        cyc(6);
        chk(mon_rst_req == 1'b1, "R8 request raised", mon_rst_req, 1);
        chk(sel_osc == 1'b1, "R8 oscillator kept", sel_osc, 1);
        osc_run = 1'b1;
        cyc(10);
        chk(mon_rst_req == 1'b0, "R8 request cleared", mon_rst_req, 0);

        // R9 monitor disabled
        wr(1'b0, 1'b0);
        cyc(5);
        osc_run = 1'b0;
        cyc(20);
        chk(mon_rst_req == 1'b0, "R9 no request", mon_rst_req, 0);
        chk(self_mode == 1'b0, "R9 no mode change", self_mode, 0);

        // R11 reset event overrides cleared bits
        osc_run = 1'b1;
        cyc(10);
        do_reset();
        cyc(1);
        chk(self_mode == 1'b1, "R11 self mode after event", self_mode, 1);
        chk(sel_osc == 1'b0, "R11 self clock selected", sel_osc, 0);
        cyc(30);
        chk(self_mode == 1'b0, "R3 recovered after event", self_mode, 0);

        // R7 fallback on loss with restored defaults
        osc_run = 1'b0;
        cyc(20);
        chk(self_mode == 1'b1, "R7 fallback to self", self_mode, 1);
        chk(mon_rst_req == 1'b0, "R7 no request", mon_rst_req, 0);

        // R10 clearing fallback while in self mode is ignored
        wr(1'b1, 1'b0);
        cyc(10);
        chk(mon_rst_req == 1'b0, "R10 no request", mon_rst_req, 0);
        chk(self_mode == 1'b1, "R10 still self", self_mode, 1);

        // R4 slow clock after loss, then an acceptable one (R3)
        half = 6;
        osc_run = 1'b1;
        cyc(60);
        chk(self_mode == 1'b1, "R4 slow clock rejected", self_mode, 1);
        half = 3;
        cyc(40);
        chk(self_mode == 1'b0, "R3 recovery after loss", self_mode, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule